// File: doc/BRIEF.md
# Address Latch Strobe Generator

This block produces the address-latch strobe of a multiplexed external bus. A separate oscillator-phase counter steps through six phases for each machine cycle. The strobe is high for the first two of those phases. While an external data-memory access is in progress, the strobe drops exactly one pulse. This gives the data cycle room on the shared address/data lines.

A control register in the special-function space carries a quiet bit. Setting the quiet bit holds the strobe low while code runs from on-chip memory, which cuts switching noise. The strobe comes back without any software action whenever an external program fetch or an external data access is flagged. It goes quiet again once neither indicator is present at a cycle boundary.

All strobe decisions are made at the start of a cycle, so a pulse is never cut short. While reset is applied, the strobe pin is not driven and a board-level weak pull-up is assumed. Reset is asserted asynchronously. It is released through a two-stage synchroniser.

Top module: `ale_gen`

## Requirements
- R1: With the quiet bit clear and no data access, `ale` is high during the clock period after each edge that samples `osc_phase` equal to 0 or 1, and low after the edges that sample phases 2 to 5. This gives two high periods out of every six.
- R2: When a cycle starts (`osc_phase` = 0) with `ext_data` high, and `ext_data` was low at the previous cycle start, that cycle's pulse is dropped. Later cycles of the same access pulse normally.
- R3: A write (`sfr_wr` = 1) to address 8EH loads the quiet bit from `sfr_wdata` bit 0. Writes to any other address, and data bits 7..1, have no effect on the strobe.
- R4: With the quiet bit set and neither `ext_fetch` nor `ext_data` high at a cycle start, `ale` stays low for that whole cycle.
- R5: With the quiet bit set, a cycle that starts with `ext_fetch` high, or with `ext_data` high (subject to R2), produces a full pulse.
- R6: Indicator changes and quiet-bit writes made after a cycle start take effect only from the next cycle start. No pulse is ever truncated or added mid-cycle.
- R7: While `rst_n` is low, `ale_oe` and `ale` are low and the quiet bit clears to 0. `ale_oe` rises after the third rising clock edge that follows the release of `rst_n`.
- R8: `ale` is never high while `ale_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_phase | input | 3 | Oscillator phase within the machine cycle, 0..5 |
| ext_fetch | input | 1 | Program fetch from external memory in progress |
| ext_data | input | 1 | External data-memory access in progress |
| sfr_wr | input | 1 | Special-function register write strobe |
| sfr_addr | input | 8 | Special-function register write address |
| sfr_wdata | input | 8 | Special-function register write data |
| ale | output | 1 | Address-latch strobe |
| ale_oe | output | 1 | Output drive enable for the strobe pin |

## Verification
Two functions can act in the same cycle. One is the pulse drop at the start of a data access. The other is the automatic wake-up from the quiet mode, since a data access with the quiet bit set both re-enables the strobe and must still lose its first pulse. The bench raises `ext_data` both with the quiet bit clear and with it set. Its behavioural model then expects a missing first pulse followed by normal pulses. A further case toggles `ext_fetch` entirely inside a cycle, and the model demands that the output ignore it.

// File: rtl/ale_pkg.sv
package ale_pkg;
  localparam int unsigned SFR_AW = 8;
  localparam int unsigned SFR_DW = 8;
  typedef logic [SFR_AW-1:0] sfr_addr_t;
  typedef logic [SFR_DW-1:0] sfr_data_t;
  localparam sfr_addr_t QUIET_REG_ADDR = 8'h8E;
  localparam int unsigned QUIET_BIT = 0;
endpackage

// File: rtl/ale_rst_sync.sv
module ale_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/ale_quiet_reg.sv
module ale_quiet_reg
  import ale_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  sfr_addr_t addr_i,
  input  logic      wbit_i,
  output logic      quiet_o
);
  logic hit;
  logic quiet_d, quiet_q;

  always_comb begin
    hit     = wr_i && (addr_i == QUIET_REG_ADDR);
    quiet_d = hit ? wbit_i : quiet_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) quiet_q <= 1'b0;
    else         quiet_q <= quiet_d;
  end

  assign quiet_o = quiet_q;

  a_r3_quiet_load: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && addr_i == QUIET_REG_ADDR) |=> (quiet_o == $past(wbit_i)));
  a_r3_other_addr: assert property (@(posedge clk) disable iff (!rst_ni)
    (!(wr_i && addr_i == QUIET_REG_ADDR)) |=> $stable(quiet_o));
endmodule

// File: rtl/ale_pulse_gen.sv
module ale_pulse_gen #(
  parameter int unsigned PHASES    = 6,
  parameter int unsigned PULSE_LEN = 2,
  localparam int unsigned PW       = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [PW-1:0] phase_i,
  input  logic          quiet_i,
  input  logic          fetch_i,
  input  logic          data_i,
  output logic          ale_o
);
  localparam logic [PW-1:0] PLEN = PW'(PULSE_LEN);

  logic cyc_start, data_first, want;
  logic seen_d, seen_q;
  logic en_d, en_q;
  logic ale_d, ale_q;

  always_comb begin
    cyc_start  = (phase_i == '0);
    data_first = data_i && !seen_q;
    want       = (!quiet_i || fetch_i || data_i) && !data_first;
    seen_d     = cyc_start ? data_i : seen_q;
    en_d       = cyc_start ? want   : en_q;
    ale_d      = (phase_i < PLEN) && en_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      en_q   <= 1'b0;
      ale_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      en_q   <= en_d;
      ale_q  <= ale_d;
    end
  end

  assign ale_o = ale_q;

  a_r1_pulse_window: assert property (@(posedge clk) disable iff (!rst_ni)
    ale_o |-> ($past(phase_i) < PLEN));
  a_r2_first_data_skip: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase_i == '0 && data_i && !seen_q) |=> !ale_o);
  a_r4_quiet_low: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase_i == '0 && quiet_i && !fetch_i && !data_i) |=> !ale_o);
  a_r6_no_mid_start: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase_i != '0 && !ale_o) |=> !ale_o);
endmodule

// File: rtl/ale_gen.sv
module ale_gen
  import ale_pkg::*;
#(
  parameter int unsigned PHASES    = 6,
  parameter int unsigned PULSE_LEN = 2,
  localparam int unsigned PW       = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     osc_phase,
  input  logic              ext_fetch,
  input  logic              ext_data,
  input  logic              sfr_wr,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [SFR_DW-1:0] sfr_wdata,
  output logic              ale,
  output logic              ale_oe
);
  logic rst_i;
  logic quiet;
  logic oe_d, oe_q;
  logic unused_wdata;

  assign unused_wdata = ^sfr_wdata[SFR_DW-1:1];

  ale_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_i)
  );

  ale_quiet_reg u_quiet (
    .clk     (clk),
    .rst_ni  (rst_i),
    .wr_i    (sfr_wr),
    .addr_i  (sfr_addr),
    .wbit_i  (sfr_wdata[QUIET_BIT]),
    .quiet_o (quiet)
  );

  ale_pulse_gen #(.PHASES(PHASES), .PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk     (clk),
    .rst_ni  (rst_i),
    .phase_i (osc_phase),
    .quiet_i (quiet),
    .fetch_i (ext_fetch),
    .data_i  (ext_data),
    .ale_o   (ale)
  );

  always_comb begin
    oe_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) oe_q <= 1'b0;
    else        oe_q <= oe_d;
  end

  assign ale_oe = oe_q;

  a_r8_quiet_when_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_oe |-> !ale);
  a_r7_oe_held_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale_oe) |-> $past(rst_n, 2));
endmodule

// File: tb/tb_ale_gen.sv
module tb_ale_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] osc_phase;
  logic       ext_fetch, ext_data, sfr_wr;
  logic [7:0] sfr_addr, sfr_wdata;
  logic       ale, ale_oe;

  int    tests = 0;
  int    fails = 0;
  int    hi_cnt = 0;
  string cur_req = "R7";

  // behavioural reference model
  int m_edges = 0;
  bit m_quiet = 0, m_prev_data = 0, m_cyc_on = 0, m_ale = 0, m_oe = 0;

  always #10 clk = ~clk;

  ale_gen dut (
    .clk(clk), .rst_n(rst_n), .osc_phase(osc_phase),
    .ext_fetch(ext_fetch), .ext_data(ext_data),
    .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .ale(ale), .ale_oe(ale_oe)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_edges = 0; m_quiet = 0; m_prev_data = 0; m_cyc_on = 0;
      m_ale = 0; m_oe = 0;
    end else begin
      if (m_edges >= 2) begin
        m_oe = 1;
        if (osc_phase == 0) begin
          m_cyc_on = (!m_quiet || ext_fetch || ext_data) &&
                     !(ext_data && !m_prev_data);
          m_prev_data = ext_data;
          m_ale = m_cyc_on;
        end else if (osc_phase == 1) m_ale = m_cyc_on;
        else m_ale = 0;
        if (sfr_wr && sfr_addr == 8'h8E) m_quiet = sfr_wdata[0];
      end
      if (m_edges < 10) m_edges = m_edges + 1;
    end
  end

  always @(negedge rst_n) begin
    m_ale = 0; m_oe = 0;
  end

  always @(negedge clk) begin
    tests++;
    if (ale !== m_ale || ale_oe !== m_oe) begin
      fails++;
      $display("FAIL %s: ale/oe actual %b/%b expected %b/%b at %0t",
               cur_req, ale, ale_oe, m_ale, m_oe, $time);
    end
    if (ale === 1'b1) hi_cnt++;
  end

  always @(negedge clk) begin
    #2;
    if (!rst_n) osc_phase <= 3'd0;
    else osc_phase <= (osc_phase == 3'd5) ? 3'd0 : osc_phase + 3'd1;
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic expect_cnt(input string req, input int exp);
    tests++;
    if (hi_cnt != exp) begin
      fails++;
      $display("FAIL %s: high count actual %0d expected %0d", req, hi_cnt, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
    run(1);
    sfr_wr = 0; sfr_addr = 0; sfr_wdata = 0;
  endtask

  task automatic to_phase(input int p);
    while (osc_phase != p[2:0]) run(1);
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 0; osc_phase = 0; ext_fetch = 0; ext_data = 0;
    sfr_wr = 0; sfr_addr = 0; sfr_wdata = 0;
    run(3);
    // R7 reset state
    tests++;
    if (ale !== 1'b0 || ale_oe !== 1'b0) begin
      fails++;
      $display("FAIL R7: reset ale/oe actual %b/%b expected 0/0", ale, ale_oe);
    end
    rst_n = 1;
    run(6);
    // R1 free-running pulses
    cur_req = "R1";
    to_phase(0); hi_cnt = 0; run(12);
    expect_cnt("R1", 4);
    // R2 data access drops one pulse
    cur_req = "R2";
    to_phase(3); ext_data = 1; to_phase(3); hi_cnt = 0; run(18);
    expect_cnt("R2", 4);
    ext_data = 0; run(12);
    // R3 other address, then the quiet register
    cur_req = "R3";
    sfr_write(8'h8F, 8'hFF); sfr_write(8'h8E, 8'hFE);
    to_phase(0); hi_cnt = 0; run(12);
    expect_cnt("R3", 4);
    sfr_write(8'h8E, 8'h01);
    // R4 quiet
    cur_req = "R4";
    to_phase(0); run(6); hi_cnt = 0; run(18);
    expect_cnt("R4", 0);
    // R5 fetch and data wake the strobe
    cur_req = "R5";
    to_phase(4); ext_fetch = 1; to_phase(4); hi_cnt = 0; run(12);
    expect_cnt("R5", 4);
    ext_fetch = 0; run(12);
    to_phase(4); ext_data = 1; hi_cnt = 0; run(18);
    expect_cnt("R5", 4);
    ext_data = 0; run(12);
    // R6 mid-cycle stimulus ignored
    cur_req = "R6";
    to_phase(2); hi_cnt = 0; ext_fetch = 1; run(3); ext_fetch = 0;
    run(9);
    expect_cnt("R6", 0);
    to_phase(3); sfr_write(8'h8E, 8'h00); hi_cnt = 0; run(1);
    expect_cnt("R6", 0);
    run(12);
    // R7 reset mid-run clears quiet bit
    cur_req = "R7";
    sfr_write(8'h8E, 8'h01); run(4);
    rst_n = 0; run(3); rst_n = 1; run(4);
    cur_req = "R8";
    to_phase(0); hi_cnt = 0; run(12);
    expect_cnt("R7", 4);
    finish_up();
  end
endmodule